// File: doc/BRIEF.md
# Registered Two-Way Octal Bus Transceiver

This block sits between two 8-bit buses, A and B. Each direction has a holding register, a clock that loads it, a source select and an output enable. The A-to-B direction drives the B bus, and the B-to-A direction drives the A bus. Each direction can pass either the live value of the opposite bus or the value its register loaded earlier.

The registers load on their own clock edges whatever the selects and enables are doing. A port can therefore sample a bus while it is not driving anything. A parameter sets whether data passes through unchanged or as its bitwise complement.

Each port is modelled as separate input, output and per-bit output-enable vectors, so the block stays synthesizable. The surrounding logic resolves the tri-state buses. When both directions are enabled and both pass live data, the two outputs drive each other's inputs. In that state the resolved buses keep their last value after every other driver lets go.

Top module: `regxcvr`

## Requirements
- R1: A rising edge of `clk_ab` loads `a_in` into the A-side register. A rising edge of `clk_ba` loads `b_in` into the B-side register.
- R2: The registers load whatever the values of `sel_ab`, `sel_ba`, `oe_ab` and `oe_ba_n`, including while both ports are disabled.
- R3: When `sel_ab` is 0, `b_out` follows the live `a_in`. When `sel_ab` is 1, `b_out` shows the A-side register. `sel_ba` picks the source of `a_out` from `b_in` or the B-side register in the same way.
- R4: `oe_ab` is active high and sets every bit of `b_oe` to 1, or every bit to 0 when it is low. `oe_ba_n` is active low and controls `a_oe` in the same way. Each enable affects only its own port.
- R5: With `INVERT`=0, output data equals the selected source. With `INVERT`=1, output data is the bitwise complement of the selected source.
- R6: If the stored and live values are equal and stay unchanged, toggling a select leaves that direction's output unchanged.
- R7: Driving `rst_n` low clears both registers to 0 without waiting for a clock edge. Reset does not change `a_oe` or `b_oe`.
- R8: With both selects at 0 and both ports enabled, the resolved A and B buses keep their last values after the external drivers change or release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Load clock for the A-side register |
| clk_ba | input | 1 | Load clock for the B-side register |
| rst_n | input | 1 | Asynchronous active-low register clear |
| sel_ab | input | 1 | B-port source: 0 live A, 1 stored |
| sel_ba | input | 1 | A-port source: 0 live B, 1 stored |
| oe_ab | input | 1 | B-port drive enable, active high |
| oe_ba_n | input | 1 | A-port drive enable, active low |
| a_in | input | W | Resolved value of bus A |
| b_in | input | W | Resolved value of bus B |
| a_out | output | W | Data the block drives onto bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_out | output | W | Data the block drives onto bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
The hardest state to reach is the bus-hold loop, because the bus values there come only from the block's two outputs driving each other. The bench starts with one port disabled, so an external driver sets bus A and the live path copies it onto bus B. It then enables the second direction, which closes the loop. Last, it changes the external value, and both buses must keep the old data. A second hard case is a load while both ports are disabled; the bench reveals it later by enabling each port with its select on the stored source.

// File: rtl/regxcvr.sv
module regxcvr #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  localparam logic [W-1:0] POL = INVERT ? {W{1'b1}} : {W{1'b0}};

  logic [W-1:0] reg_a, reg_b;
  logic [W-1:0] pick_ab, pick_ba;
  logic         armed_ab, armed_ba;

  always_ff @(posedge clk_ab or negedge rst_n)
    if (!rst_n) reg_a <= '0;
    else        reg_a <= a_in;

  always_ff @(posedge clk_ba or negedge rst_n)
    if (!rst_n) reg_b <= '0;
    else        reg_b <= b_in;

  // and-or mux with consensus term: no hazard when both sources agree
  assign pick_ab = ({W{sel_ab}} & reg_a) | ({W{~sel_ab}} & a_in) | (reg_a & a_in);
  assign pick_ba = ({W{sel_ba}} & reg_b) | ({W{~sel_ba}} & b_in) | (reg_b & b_in);

  assign b_out = pick_ab ^ POL;
  assign a_out = pick_ba ^ POL;
  assign b_oe  = {W{oe_ab}};
  assign a_oe  = {W{~oe_ba_n}};

  always_ff @(posedge clk_ab or negedge rst_n)
    if (!rst_n) armed_ab <= 1'b0;
    else        armed_ab <= 1'b1;

  always_ff @(posedge clk_ba or negedge rst_n)
    if (!rst_n) armed_ba <= 1'b0;
    else        armed_ba <= 1'b1;

  // R1
  capture_ab_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    1'b1 |=> (!sel_ab || b_out == ($past(a_in) ^ POL)));
  // R1
  capture_ba_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    1'b1 |=> (!sel_ba || a_out == ($past(b_in) ^ POL)));
  // R4
  b_enable_shape_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_oe == '0) || (b_oe == '1));
  // R4
  a_enable_shape_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (a_oe == '0) || (a_oe == '1));
  // R6
  no_glitch_ab_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (armed_ab && $stable(a_in) && $stable(reg_a) && reg_a == a_in) |-> $stable(b_out));
  // R6
  no_glitch_ba_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (armed_ba && $stable(b_in) && $stable(reg_b) && reg_b == b_in) |-> $stable(a_out));
endmodule

// File: tb/tb_regxcvr.sv
module tb_regxcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic clk_ab = 0, clk_ba = 0, rst_n = 0;
  logic sel_ab = 0, sel_ba = 0, oe_ab = 0, oe_ba_n = 1;
  logic [W-1:0] ext_a = '0, ext_b = '0;
  logic [W-1:0] bus_a, bus_b, a_out, a_oe, b_out, b_oe;
  logic [W-1:0] ia_out, ia_oe, ib_out, ib_oe;

  assign bus_a = (a_oe & a_out) | (~a_oe & ext_a);
  assign bus_b = (b_oe & b_out) | (~b_oe & ext_b);

  regxcvr #(.W(W), .INVERT(1'b0)) dut (
    .clk_ab, .clk_ba, .rst_n, .sel_ab, .sel_ba, .oe_ab, .oe_ba_n,
    .a_in(bus_a), .b_in(bus_b), .a_out, .a_oe, .b_out, .b_oe);

  regxcvr #(.W(W), .INVERT(1'b1)) dut_inv (
    .clk_ab, .clk_ba, .rst_n, .sel_ab, .sel_ba, .oe_ab, .oe_ba_n,
    .a_in(ext_a), .b_in(ext_b), .a_out(ia_out), .a_oe(ia_oe),
    .b_out(ib_out), .b_oe(ib_oe));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(input bit ab, input bit ba);
    #1;
    clk_ab = ab; clk_ba = ba;
    #1;
    clk_ab = 0; clk_ba = 0;
    #1;
  endtask

  // {sel_ab, oe_ab, sel_ba, oe_ba_n, cap_ab, cap_ba, ext_a, ext_b, exp_bus_a, exp_bus_b}
  localparam int NV = 9;
  localparam logic [37:0] VEC [NV] = '{
    {6'b010100, 8'h3C, 8'h00, 8'h3C, 8'h3C},  // R3 live A->B
    {6'b110110, 8'hA5, 8'h00, 8'hA5, 8'hA5},  // R1 load A, stored
    {6'b110100, 8'h11, 8'h00, 8'h11, 8'hA5},  // R3 stored held
    {6'b010100, 8'h11, 8'h00, 8'h11, 8'h11},  // R3 back to live
    {6'b000000, 8'h00, 8'hC3, 8'hC3, 8'hC3},  // R3 live B->A
    {6'b001001, 8'h00, 8'h7E, 8'h7E, 8'h7E},  // R1 load B, stored
    {6'b000111, 8'h0F, 8'hF0, 8'h0F, 8'hF0},  // R2 load while disabled
    {6'b110100, 8'h99, 8'h00, 8'h99, 8'h0F},  // R2 A stored shown
    {6'b001000, 8'h00, 8'h55, 8'hF0, 8'h55}   // R2 B stored shown
  };

  initial begin
    #100000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #7;
    // R7 enables unaffected by reset
    oe_ab = 1; oe_ba_n = 0;
    #1;
    check("R7 b_oe during reset", b_oe, 8'hFF);
    check("R7 a_oe during reset", a_oe, 8'hFF);
    sel_ab = 1; sel_ba = 1;
    #1;
    check("R7 reset A reg", b_out, 8'h00);
    check("R7 reset B reg", a_out, 8'h00);
    check("R5 R7 inverted reset", ib_out, 8'hFF);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      sel_ab = v[37]; oe_ab = v[36]; sel_ba = v[35]; oe_ba_n = v[34];
      ext_a = v[31:24]; ext_b = v[23:16];
      pulse(v[33], v[32]);
      @(negedge clk);
      check($sformatf("R1-3 vec%0d bus A", i), bus_a, v[15:8]);
      check($sformatf("R1-3 vec%0d bus B", i), bus_b, v[7:0]);
    end

    // R4 independent enables
    oe_ab = 1; oe_ba_n = 1; #1;
    check("R4 b_oe on", b_oe, 8'hFF);
    check("R4 a_oe off", a_oe, 8'h00);
    oe_ab = 0; oe_ba_n = 0; #1;
    check("R4 b_oe off", b_oe, 8'h00);
    check("R4 a_oe on", a_oe, 8'hFF);

    // R5 inverting variant, live path
    sel_ab = 0; sel_ba = 0; ext_a = 8'h36; ext_b = 8'h81; #1;
    check("R5 inverted A->B", ib_out, 8'hC9);
    check("R5 inverted B->A", ia_out, 8'h7E);

    // R6 select toggles with equal sources
    oe_ab = 1; oe_ba_n = 1; ext_a = 8'h5C;
    pulse(1, 0);
    for (int k = 0; k < 4; k++) begin
      sel_ab = ~sel_ab;
      pulse(1, 0);
      check("R6 output steady across select", bus_b, 8'h5C);
    end

    // R8 bus hold loop
    sel_ab = 0; sel_ba = 0; oe_ab = 1; oe_ba_n = 1; ext_a = 8'h6B; #2;
    check("R8 setup bus B", bus_b, 8'h6B);
    oe_ba_n = 0; #2;
    ext_a = 8'h00; ext_b = 8'hFF; #2;
    check("R8 hold bus A", bus_a, 8'h6B);
    check("R8 hold bus B", bus_b, 8'h6B);

    // R7 asynchronous clear mid-run
    oe_ab = 1; oe_ba_n = 1; sel_ab = 1; ext_a = 8'h44;
    pulse(1, 0);
    check("R7 pre-reset stored", bus_b, 8'h44);
    rst_n = 0; #1;
    check("R7 async clear", bus_b, 8'h00);
    rst_n = 1;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule